// File: doc/BRIEF.md
# Reed-Solomon (255,239) Byte-Serial Encoder

This block adds forward error correction to a stream of 255-byte transport sub-rows. One byte enters per clock. A start strobe marks the first message byte of each block. The 239 message bytes are copied unchanged to the output. The block then appends 16 check bytes, which it computes in a feedback shift-register divider over GF(256). The resulting codeword can repair up to eight corrupted bytes.

The field is built on x^8 + x^4 + x^3 + x^2 + 1 (0x11D), with α = 0x02. The generator polynomial is the product of (z + α^i) for i = 0 to 15. Every byte, message or check, reaches the output exactly two clocks after its input slot. While the check bytes are being emitted, the divider registers shift towards the top and fill with zeros. The next block can therefore follow immediately, without a reset. Blocks may be separated by idle time. A start that arrives inside a block abandons that block and begins a new one.

Top module: `rs_fec_encoder`

## Requirements
- R1: Message bytes are passed through unchanged. The byte presented in input slot k (k = 1 to 239, where slot 1 carries start) appears on `dataOut` for codeword position k.
- R2: Positions 240 to 255 carry the remainder of m(z)·z^16 divided by g(z), highest-order coefficient first. Evaluated at α^0 through α^15, the whole 255-byte codeword is zero. An all-zero message gives all-zero check bytes.
- R3: Every codeword byte appears on `dataOut` exactly two clocks after its input slot. The first message byte is therefore not visible one clock after start.
- R4: A new start exactly 255 clocks after the previous one produces a correct codeword, with no reset in between.
- R5: `dataIn` is ignored during the 16 check-byte slots. Any value presented there leaves the check bytes unchanged.
- R6: When no block is in progress (more than 255 clocks after the last start), `dataOut` is 0x00 two clocks later.
- R7: A start during a block discards the partial block. The following bytes form a new codeword whose check bytes are independent of the discarded data.
- R8: Synchronous active-high reset clears the divider and the output. `dataOut` is 0x00 after reset, and a block started after a reset in mid-block is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Marks the first message byte of a block |
| dataIn | input | 8 | Message byte input |
| dataOut | output | 8 | Codeword byte output, two clocks behind the input |

## Verification
The main function is exercised with several messages:
- An all-zero message isolates the pass-through path from any parity error.
- A ramp and a pseudo-random message exercise every multiplier tap. They are checked against a reference division and against sixteen syndromes, which would catch reversed check-byte order or a wrong generator.
- A message that is zero except for its last byte shows whether the final feedback term is applied before the shift-out.

Paired runs cover the remaining requirements:
- The same message is sent with different filler during the check-byte slots.
- Blocks are sent back to back and after an aborted partial block.
- A block follows a reset in mid-block.

These runs separate a correct self-clearing divider from one that leaks state between blocks.

// File: rtl/rs_fec_pkg.sv
package rs_fec_pkg;

  localparam int SymW = 8;
  localparam logic [8:0] FieldPoly = 9'h11D;
  localparam int MaxRoots = 64;

  typedef struct packed {
    logic clear;   // start of block: drop prior divider state
    logic absorb;  // message slot: feed the divider
    logic shift;   // check slot: emit top register, shift with zero feedback
  } encStrobe_t;

  function automatic logic [SymW-1:0] gfMul(logic [SymW-1:0] a, logic [SymW-1:0] b);
    logic [SymW-1:0] acc;
    logic [SymW-1:0] x;
    acc = '0;
    x = a;
    for (int i = 0; i < SymW; i++) begin
      if (b[i]) acc = acc ^ x;
      x = x[SymW-1] ? ((x << 1) ^ FieldPoly[SymW-1:0]) : (x << 1);
    end
    return acc;
  endfunction

  // Coefficient idx of prod_{r=0}^{nRoots-1} (z + alpha^r), low order first.
  function automatic logic [SymW-1:0] gfGenCoef(int idx, int nRoots);
    logic [SymW-1:0] p [MaxRoots+1];
    logic [SymW-1:0] root;
    for (int j = 0; j <= MaxRoots; j++) p[j] = '0;
    p[0] = 8'h01;
    root = 8'h01;
    for (int r = 0; r < nRoots; r++) begin
      for (int j = r + 1; j >= 1; j--) p[j] = p[j-1] ^ gfMul(p[j], root);
      p[0] = gfMul(p[0], root);
      root = gfMul(root, 8'h02);
    end
    return p[idx];
  endfunction

endpackage

// File: rtl/rs_fec_ctrl.sv
module rs_fec_ctrl
  import rs_fec_pkg::*;
#(
  parameter int MsgLen = 239,
  parameter int ParLen = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output encStrobe_t strobe
);

  localparam int BlkLen = MsgLen + ParLen;
  localparam int CntW = $clog2(BlkLen + 1);

  logic [CntW-1:0] slotCnt;
  logic [CntW-1:0] slotNow;

  // slot number of the byte on dataIn this cycle; 0 means idle
  always_comb begin
    if (start)
      slotNow = CntW'(1);
    else if (slotCnt != '0 && slotCnt < CntW'(BlkLen))
      slotNow = slotCnt + CntW'(1);
    else
      slotNow = '0;
  end

  always_comb begin
    strobe.clear  = start;
    strobe.absorb = (slotNow != '0) && (slotNow <= CntW'(MsgLen));
    strobe.shift  = slotNow > CntW'(MsgLen);
  end

  always_ff @(posedge clk) begin
    if (rst) slotCnt <= '0;
    else     slotCnt <= slotNow;
  end

endmodule

// File: rtl/rs_fec_dp.sv
module rs_fec_dp
  import rs_fec_pkg::*;
#(
  parameter int ParLen = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  encStrobe_t      strobe,
  input  logic [SymW-1:0] dataIn,
  output logic [SymW-1:0] dataOut
);

  logic [SymW-1:0] parReg  [ParLen];
  logic [SymW-1:0] parNext [ParLen];
  logic [SymW-1:0] fbTop;
  logic [SymW-1:0] feedback;
  logic [SymW-1:0] dataQ;

  // On a start the old remainder is treated as zero; in check slots feedback is zero.
  assign fbTop    = strobe.clear ? '0 : parReg[ParLen-1];
  assign feedback = strobe.absorb ? (dataIn ^ fbTop) : '0;

  for (genvar gi = 0; gi < ParLen; gi++) begin : g_stage
    localparam logic [SymW-1:0] Coef = gfGenCoef(gi, ParLen);
    logic [SymW-1:0] below;
    if (gi == 0) begin : g_first
      assign below = '0;
    end else begin : g_rest
      assign below = strobe.clear ? '0 : parReg[gi-1];
    end
    assign parNext[gi] = below ^ gfMul(feedback, Coef);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ParLen; i++) parReg[i] <= '0;
    end else if (strobe.absorb || strobe.shift) begin
      parReg <= parNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataQ   <= '0;
      dataOut <= '0;
    end else begin
      if (strobe.absorb)     dataQ <= dataIn;
      else if (strobe.shift) dataQ <= parReg[ParLen-1];
      else                   dataQ <= '0;
      dataOut <= dataQ;
    end
  end

endmodule

// File: rtl/rs_fec_encoder.sv
module rs_fec_encoder #(
  parameter int MsgLen = 239,
  parameter int ParLen = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] dataIn,
  output logic [7:0] dataOut
);

  rs_fec_pkg::encStrobe_t strobe;

  rs_fec_ctrl #(.MsgLen(MsgLen), .ParLen(ParLen)) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .strobe (strobe)
  );

  rs_fec_dp #(.ParLen(ParLen)) i_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

endmodule

// File: rtl/rs_fec_encoder_chk.sv
module rs_fec_encoder_chk #(
  parameter int MsgLen = 239,
  parameter int ParLen = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [7:0] dataIn,
  input logic [7:0] dataOut
);

  localparam int BlkLen = MsgLen + ParLen;
  localparam int CntW = $clog2(BlkLen + 1);
  localparam logic [1:0] KIdle = 2'd0;
  localparam logic [1:0] KMsg  = 2'd1;
  localparam logic [1:0] KPar  = 2'd2;

  logic [CntW-1:0] cnt;
  logic [CntW-1:0] posNow;
  logic [1:0] kindNow, kind1, kind2;
  logic [7:0] data1, data2;
  logic zeroBlk, zeroNow, zero1, zero2;

  always_comb begin
    if (start) posNow = CntW'(1);
    else if (cnt != '0 && cnt < CntW'(BlkLen)) posNow = cnt + CntW'(1);
    else posNow = '0;
    if (posNow == '0) kindNow = KIdle;
    else if (posNow <= CntW'(MsgLen)) kindNow = KMsg;
    else kindNow = KPar;
    if (start) zeroNow = (dataIn == 8'h00);
    else if (kindNow == KMsg) zeroNow = zeroBlk && (dataIn == 8'h00);
    else zeroNow = zeroBlk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; kind1 <= KIdle; kind2 <= KIdle;
      data1 <= '0; data2 <= '0;
      zeroBlk <= 1'b1; zero1 <= 1'b1; zero2 <= 1'b1;
    end else begin
      cnt <= posNow;
      kind1 <= kindNow; kind2 <= kind1;
      data1 <= dataIn;  data2 <= data1;
      zeroBlk <= zeroNow; zero1 <= zeroNow; zero2 <= zero1;
    end
  end

  // R8: output is quiet on the first cycle after reset
  p_reset_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> dataOut == 8'h00);

  // R1 and R3: message byte shows up two clocks later, unchanged
  p_pass_latency_r1: assert property (@(posedge clk) disable iff (rst)
    kind2 == KMsg |-> dataOut == data2);

  // R6: idle slots give zero output
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    kind2 == KIdle |-> dataOut == 8'h00);

  // R2: an all-zero message yields all-zero check bytes
  p_zero_parity_r2: assert property (@(posedge clk) disable iff (rst)
    (kind2 == KPar && zero2) |-> dataOut == 8'h00);

endmodule

bind rs_fec_encoder rs_fec_encoder_chk #(.MsgLen(MsgLen), .ParLen(ParLen)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .dataIn  (dataIn),
  .dataOut (dataOut)
);

// File: tb/test_rs_fec_encoder.sv
module test_rs_fec_encoder;

  localparam int MsgLen = 239;
  localparam int ParLen = 16;
  localparam int BlkLen = MsgLen + ParLen;
  localparam int LogN = 1024;

  typedef logic [7:0] msg_t [MsgLen];
  typedef logic [7:0] cw_t [BlkLen];
  typedef logic [7:0] par_t [ParLen];

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] dataOut;

  int nRun = 0;
  int nFail = 0;
  int cyc = 0;
  logic [7:0] outLog [LogN];
  logic [7:0] genPoly [ParLen];

  always #10 clk = ~clk;

  rs_fec_encoder #(.MsgLen(MsgLen), .ParLen(ParLen)) i_rs_fec_encoder (
    .clk(clk), .rst(rst), .start(start), .dataIn(dataIn), .dataOut(dataOut)
  );

  always @(negedge clk) begin
    outLog[cyc % LogN] = dataOut;
    cyc = cyc + 1;
  end

  function automatic logic [7:0] tbMul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] tbPow(int e);
    logic [7:0] v = 8'h01;
    for (int i = 0; i < e; i++) v = tbMul(v, 8'h02);
    return v;
  endfunction

  task automatic buildGen();
    logic [7:0] p [ParLen+1];
    for (int j = 0; j <= ParLen; j++) p[j] = 8'h00;
    p[0] = 8'h01;
    for (int r = 0; r < ParLen; r++) begin
      for (int j = r + 1; j >= 1; j--) p[j] = p[j-1] ^ tbMul(p[j], tbPow(r));
      p[0] = tbMul(p[0], tbPow(r));
    end
    for (int j = 0; j < ParLen; j++) genPoly[j] = p[j];
  endtask

  // remainder of m(z)*z^16 mod g(z); index 15 is the highest order
  function automatic par_t refParity(msg_t m);
    par_t rem;
    logic [7:0] fb;
    for (int j = 0; j < ParLen; j++) rem[j] = 8'h00;
    for (int k = 0; k < MsgLen; k++) begin
      fb = m[k] ^ rem[ParLen-1];
      for (int j = ParLen - 1; j >= 1; j--) rem[j] = rem[j-1] ^ tbMul(genPoly[j], fb);
      rem[0] = tbMul(genPoly[0], fb);
    end
    return rem;
  endfunction

  function automatic int badSyndromes(cw_t c);
    int bad = 0;
    logic [7:0] acc;
    logic [7:0] x;
    for (int j = 0; j < ParLen; j++) begin
      x = tbPow(j);
      acc = 8'h00;
      for (int k = 0; k < BlkLen; k++) acc = tbMul(acc, x) ^ c[k];
      if (acc != 8'h00) bad++;
    end
    return bad;
  endfunction

  function automatic msg_t mkMsg(int mode, int seed);
    msg_t m;
    logic [7:0] s = 8'(seed) | 8'h01;
    for (int k = 0; k < MsgLen; k++) begin
      case (mode)
        0: m[k] = 8'h00;
        1: m[k] = 8'(k + 1);
        2: begin s = s[7] ? ((s << 1) ^ 8'h1D) : (s << 1); m[k] = s ^ 8'(seed); end
        default: m[k] = (k == MsgLen - 1) ? 8'hFF : 8'h00;
      endcase
    end
    return m;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic driveBytes(msg_t m, int n, logic [7:0] junk, output int startN);
    startN = 0;
    for (int k = 0; k < n; k++) begin
      tick();
      if (k == 0) startN = cyc - 1;
      start = (k == 0);
      dataIn = (k < MsgLen) ? m[k] : (junk ^ 8'(k));
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      tick();
      start = 1'b0;
      dataIn = 8'h5A ^ 8'(i);
    end
  endtask

  task automatic waitLog(int startN);
    while (cyc < startN + BlkLen + 2) @(negedge clk);
    #1;
  endtask

  task automatic verifyBlock(string tag, msg_t m, int startN);
    cw_t c;
    par_t p;
    int passErr = 0;
    int parErr = 0;
    waitLog(startN);
    for (int k = 0; k < BlkLen; k++) c[k] = outLog[(startN + 2 + k) % LogN];
    p = refParity(m);
    for (int k = 0; k < MsgLen; k++) if (c[k] != m[k]) passErr++;
    for (int j = 0; j < ParLen; j++) if (c[MsgLen + j] != p[ParLen-1-j]) parErr++;
    check({"R1 ", tag}, "message bytes differing", passErr, 0);
    check({"R2 ", tag}, "check bytes differing from reference", parErr, 0);
    check({"R2 ", tag}, "nonzero syndromes", badSyndromes(c), 0);
  endtask

  task automatic doReset();
    tick(); rst = 1'b1; start = 1'b0;
    tick(); tick(); tick();
    check("R8", "dataOut during reset", int'(dataOut), 0);
    rst = 1'b0;
  endtask

  task automatic t_zeroBlock();
    int s;
    idle(3);
    driveBytes(mkMsg(0, 0), BlkLen, 8'h00, s);
    verifyBlock("zero message", mkMsg(0, 0), s);
  endtask

  task automatic t_rampAndIdle();
    int s;
    int nz = 0;
    driveBytes(mkMsg(1, 0), BlkLen, 8'h33, s);
    idle(6);
    verifyBlock("ramp", mkMsg(1, 0), s);
    for (int k = BlkLen + 2; k < BlkLen + 6; k++) if (outLog[(s + k) % LogN] != 8'h00) nz++;
    check("R6", "nonzero idle outputs", nz, 0);
  endtask

  task automatic t_latency();
    msg_t m = mkMsg(2, 77);
    int s;
    m[0] = 8'hA5;
    idle(4);
    driveBytes(m, BlkLen, 8'h11, s);
    idle(3);
    check("R3", "output one clock after start", int'(outLog[(s + 1) % LogN]), 0);
    check("R3", "output two clocks after start", int'(outLog[(s + 2) % LogN]), 8'hA5);
    verifyBlock("latency block", m, s);
  endtask

  task automatic t_backToBack();
    int s1, s2, s3;
    driveBytes(mkMsg(2, 5), BlkLen, 8'h00, s1);
    driveBytes(mkMsg(2, 200), BlkLen, 8'h00, s2);
    driveBytes(mkMsg(3, 0), BlkLen, 8'h00, s3);
    check("R4", "start spacing", s2 - s1, BlkLen);
    verifyBlock("R4 first", mkMsg(2, 5), s1);
    verifyBlock("R4 second", mkMsg(2, 200), s2);
    verifyBlock("R4 last-byte only", mkMsg(3, 0), s3);
  endtask

  task automatic t_ignoreParitySlots();
    int s1, s2;
    driveBytes(mkMsg(2, 9), BlkLen, 8'h00, s1);
    driveBytes(mkMsg(2, 9), BlkLen, 8'hFF, s2);
    verifyBlock("R5 filler 00", mkMsg(2, 9), s1);
    verifyBlock("R5 filler FF", mkMsg(2, 9), s2);
  endtask

  task automatic t_restart();
    int s0, s1;
    driveBytes(mkMsg(2, 31), 100, 8'h00, s0);
    driveBytes(mkMsg(1, 0), BlkLen, 8'h44, s1);
    check("R7", "restart offset", s1 - s0, 100);
    verifyBlock("R7 after aborted block", mkMsg(1, 0), s1);
  endtask

  task automatic t_midReset();
    int s0, s1;
    driveBytes(mkMsg(2, 61), 60, 8'h00, s0);
    doReset();
    idle(2);
    driveBytes(mkMsg(2, 90), BlkLen, 8'h22, s1);
    verifyBlock("R8 after mid-block reset", mkMsg(2, 90), s1);
    check("R8", "first start offset", (s1 > s0) ? 1 : 0, 1);
  endtask

  initial begin
    #(200000 * 20);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun + 1, nFail);
    $finish;
  end

  initial begin
    buildGen();
    tick(); tick(); tick();
    check("R8", "dataOut after reset", int'(dataOut), 0);
    rst = 1'b0;
    t_zeroBlock();
    t_rampAndIdle();
    t_latency();
    t_backToBack();
    t_ignoreParitySlots();
    t_restart();
    t_midReset();
    idle(3);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule